// File: doc/BRIEF.md
# Shared-Pin Strap Capture and Clock Role Selector

This block sits between the pad ring and the clock dividers of a clock generator in which several pins serve twice. While power-on reset is held and every shared pad is tri-stated, the pads are read as configuration straps: four frequency-select bits, two bank-mode bits, a pin-24 mode bit and a 24/48 MHz choice. Once the straps are captured, the block decides what each shared pad carries. It produces clock enables for the PCI and HyperTransport outputs and a role code for each of the four bank pads. It also enables the reference and fixed-frequency outputs that were straps a moment earlier.

Two run-time functions sit on top of that. When pin 24 has become a stop input, a low level on it halts every gated PCI clock. The free-running PCI clock and the HyperTransport clocks keep running. Stopping and restarting only happen in a cycle that the clock generator marks as the low phase of the gated clock, so no shortened pulse reaches a pad. A gear-ratio change or a watchdog expiry drives an active-low reset request low for a fixed number of reference cycles. Clocks themselves are not generated here: every output is an enable or a select.

Top module: `strap_pinmux`

## Requirements
- R1: The strap inputs are captured once, on the first rising clock edge with `rst_n` high. After that, later values on the strap inputs have no effect on `fs_q`, `sel_24m` or any pin assignment until the next reset.
- R2: While reset is asserted, and in the cycle after capture, the following are all 0: `ref_oe`, `pcif_en`, `pin24_oe`, `pci_en`, `htt_en` and `pin_role`. From the second edge after reset release, `ref_oe` and `pcif_en` are 1.
- R3: `pin_role` holds one 2-bit code per bank pad, in this order: bits 1:0 pin 6, bits 3:2 pin 7, bits 5:4 pin 8, bits 7:6 pin 11. The codes are 0 = input, 1 = PCI clock, 2 = HyperTransport clock. With both bank-mode straps at 0, pins 6, 7 and 8 are code 2 and pin 11 is code 1, `htt_en` = 4'b0111 and PCI clock 10 is enabled.
- R4: With mode B = 1 and mode A = 0, pin 6 is an input (code 0) and pins 7, 8 and 11 are code 2, with `htt_en` = 4'b1110. With both straps at 1, pin 6 is an input and pins 7, 8 and 11 are code 1, with PCI clocks 8 to 10 enabled.
- R5: With mode A = 1 and mode B = 0, all four bank pads are code 1, PCI clocks 7 to 10 are enabled and `htt_en` is 0.
- R6: When the pin-24 strap is 0, `pin24_oe` is 1 and PCI clock 6 is enabled. When it is 1, pin 24 is the stop input, `pin24_oe` is 0 and PCI clock 6 is absent. PCI clocks 0 to 5 are always present after release.
- R7: While the stop input is low and pin 24 is a stop input, every bit of `pci_en` is 0, and `pcif_en` and `htt_en` stay unchanged. When pin 24 is an output, `pin24_in` has no effect.
- R8: A change of the stop state is taken on a rising edge only when `gate_low` is 1 at that edge. `pci_en` follows in the cycle after that edge and is otherwise held.
- R9: `sel_24m` equals the captured 24/48 strap, where 1 selects 24 MHz and 0 selects 48 MHz.
- R10: After release, a `gear_change` or `wd_timeout` pulse at a rising edge drives `wdreset_n` low for exactly WDR_CYCLES (16) cycles starting the next cycle. A new pulse during that window restarts the count. Pulses before release are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| fs_strap_in | input | 4 | Frequency-select strap levels read from the shared pads |
| mode_a_in | input | 1 | Bank mode A strap level |
| mode_b_in | input | 1 | Bank mode B strap level |
| mode_c_in | input | 1 | Pin-24 mode strap level |
| sel_strap_in | input | 1 | 24/48 MHz select strap level |
| pin24_in | input | 1 | Level on pin 24, the stop input when enabled (active low) |
| gate_low | input | 1 | High while the gated PCI clock is in its low phase |
| gear_change | input | 1 | Frequency gear ratio change pulse |
| wd_timeout | input | 1 | Watchdog expiry pulse |
| fs_q | output | 4 | Captured frequency-select code |
| sel_24m | output | 1 | Captured 24/48 choice (1 = 24 MHz) |
| ref_oe | output | 1 | Output enable for the reference and 48 MHz pads |
| pcif_en | output | 1 | Free-running PCI clock enable |
| pci_en | output | 11 | PCI clock enables 0 to 10 |
| htt_en | output | 4 | HyperTransport clock enables 0 to 3 |
| pin_role | output | 8 | Role code per bank pad |
| pin24_oe | output | 1 | Pin 24 drives PCI clock 6 |
| wdreset_n | output | 1 | Reset request, active low |

## Verification
Strap capture lands on the first edge after reset release, and every enable comes up one edge later. The pad roles therefore show at the second sample after `rst_n` rises. A stop or restart shows in `pci_en` one cycle after the edge where `gate_low` was high. `wdreset_n` falls one cycle after the trigger edge and rises 16 cycles later. The bench keeps a behavioural model that takes the same edges and compares every output at each falling edge. No check has to guess a latency: a result that is one cycle early or late is reported on the cycle where it differs.

// File: rtl/strap_pinmux_pkg.sv
package strap_pinmux_pkg;
    localparam int NUM_FS     = 4;
    localparam int NUM_SHARED = 4;
    localparam int NUM_PCI    = 11;
    localparam int NUM_HTT    = 4;
    localparam int ROLE_W     = 2;

    typedef enum logic [ROLE_W-1:0] {
        ROLE_IN  = 2'd0,
        ROLE_PCI = 2'd1,
        ROLE_HTT = 2'd2
    } pin_role_e;

    typedef struct packed {
        logic [NUM_FS-1:0] fs;
        logic              mode_a;
        logic              mode_b;
        logic              mode_c;
        logic              sel24;
    } strap_t;
endpackage

// File: rtl/strap_latch.sv
module strap_latch
    import strap_pinmux_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  strap_t strap_in,
    output strap_t strap_q,
    output logic   released
);
    typedef struct packed {
        logic   sampled;
        logic   released;
        strap_t straps;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.sampled) begin
            st_d.straps  = strap_in;
            st_d.sampled = 1'b1;
        end else begin
            st_d.released = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strap_q  = st_q.straps;
    assign released = st_q.released;
endmodule

// File: rtl/pci_stop_gate.sv
module pci_stop_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_low,
    input  logic stop_req,
    output logic run
);
    typedef struct packed {
        logic run;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (gate_low) st_d.run = ~stop_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{run: 1'b1};
        else        st_q <= st_d;
    end

    assign run = st_q.run;
endmodule

// File: rtl/wdr_pulse.sv
module wdr_pulse #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic wdreset_n
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } wdr_st_t;

    wdr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig)                st_d.cnt = CNT_W'(CYCLES);
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wdreset_n = (st_q.cnt == '0);
endmodule

// File: rtl/pin_mux.sv
module pin_mux
    import strap_pinmux_pkg::*;
(
    input  strap_t                       straps,
    input  logic                         released,
    input  logic                         run,
    output logic [NUM_PCI-1:0]           pci_en,
    output logic [NUM_HTT-1:0]           htt_en,
    output logic [ROLE_W*NUM_SHARED-1:0] pin_role,
    output logic                         pin24_oe
);
    pin_role_e role [NUM_SHARED];
    logic [NUM_PCI-1:0] present;

    always_comb begin
        present = '0;
        htt_en  = '0;
        for (int k = 0; k < NUM_SHARED; k++) role[k] = ROLE_IN;
        if (released) begin
            present[5:0] = '1;
            present[6]   = ~straps.mode_c;
            present[7]   = straps.mode_a & ~straps.mode_b;
            present[8]   = straps.mode_a;
            present[9]   = straps.mode_a;
            present[10]  = straps.mode_a | ~straps.mode_b;
            unique case ({straps.mode_a, straps.mode_b})
                2'b00: begin
                    for (int k = 0; k < NUM_SHARED - 1; k++) role[k] = ROLE_HTT;
                    role[NUM_SHARED-1] = ROLE_PCI;
                    htt_en = 4'b0111;
                end
                2'b01: begin
                    for (int k = 1; k < NUM_SHARED; k++) role[k] = ROLE_HTT;
                    htt_en = 4'b1110;
                end
                2'b10: begin
                    for (int k = 0; k < NUM_SHARED; k++) role[k] = ROLE_PCI;
                end
                default: begin
                    for (int k = 1; k < NUM_SHARED; k++) role[k] = ROLE_PCI;
                end
            endcase
        end
        pci_en   = present & {NUM_PCI{run}};
        pin24_oe = released & ~straps.mode_c;
        for (int k = 0; k < NUM_SHARED; k++) pin_role[ROLE_W*k +: ROLE_W] = role[k];
    end
endmodule

// File: rtl/strap_pinmux.sv
module strap_pinmux
    import strap_pinmux_pkg::*;
#(
    parameter int WDR_CYCLES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_FS-1:0]            fs_strap_in,
    input  logic                         mode_a_in,
    input  logic                         mode_b_in,
    input  logic                         mode_c_in,
    input  logic                         sel_strap_in,
    input  logic                         pin24_in,
    input  logic                         gate_low,
    input  logic                         gear_change,
    input  logic                         wd_timeout,
    output logic [NUM_FS-1:0]            fs_q,
    output logic                         sel_24m,
    output logic                         ref_oe,
    output logic                         pcif_en,
    output logic [NUM_PCI-1:0]           pci_en,
    output logic [NUM_HTT-1:0]           htt_en,
    output logic [ROLE_W*NUM_SHARED-1:0] pin_role,
    output logic                         pin24_oe,
    output logic                         wdreset_n
);
    strap_t strap_in, strap_q;
    logic   released, run, stop_req;

    assign strap_in = '{fs: fs_strap_in, mode_a: mode_a_in, mode_b: mode_b_in,
                        mode_c: mode_c_in, sel24: sel_strap_in};

    strap_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_in (strap_in),
        .strap_q  (strap_q),
        .released (released)
    );

    assign stop_req = released & strap_q.mode_c & ~pin24_in;

    pci_stop_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_low (gate_low),
        .stop_req (stop_req),
        .run      (run)
    );

    wdr_pulse #(.CYCLES(WDR_CYCLES)) u_wdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (released & (gear_change | wd_timeout)),
        .wdreset_n (wdreset_n)
    );

    pin_mux u_mux (
        .straps   (strap_q),
        .released (released),
        .run      (run),
        .pci_en   (pci_en),
        .htt_en   (htt_en),
        .pin_role (pin_role),
        .pin24_oe (pin24_oe)
    );

    assign fs_q    = strap_q.fs;
    assign sel_24m = strap_q.sel24;
    assign ref_oe  = released;
    assign pcif_en = released;
endmodule

// File: rtl/strap_pinmux_checker.sv
module strap_pinmux_checker
    import strap_pinmux_pkg::*;
#(
    parameter int WDR_CYCLES = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         gate_low,
    input logic                         gear_change,
    input logic                         wd_timeout,
    input logic [NUM_FS-1:0]            fs_q,
    input logic                         sel_24m,
    input logic                         ref_oe,
    input logic                         pcif_en,
    input logic [NUM_PCI-1:0]           pci_en,
    input logic [NUM_HTT-1:0]           htt_en,
    input logic [ROLE_W*NUM_SHARED-1:0] pin_role,
    input logic                         pin24_oe,
    input logic                         wdreset_n
);
    localparam int LR_W = $clog2(WDR_CYCLES + 2);
    logic [LR_W-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               low_run <= '0;
        else if (ref_oe && (gear_change || wd_timeout)) low_run <= '0;
        else if (!wdreset_n)                      low_run <= low_run + 1'b1;
        else                                      low_run <= '0;
    end

    AST_QUIET_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_oe |-> (pci_en == '0 && htt_en == '0 && pin_role == '0 && !pin24_oe && !pcif_en)); // R2
    AST_STRAPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ref_oe |=> ($stable(fs_q) && $stable(sel_24m) && ref_oe)); // R1
    AST_ROLE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_role[1:0] != 2'b11 && pin_role[3:2] != 2'b11 &&
         pin_role[5:4] != 2'b11 && pin_role[7:6] != 2'b11)); // R3
    AST_PIN6_INPUT_WITH_HTT3: assert property (@(posedge clk) disable iff (!rst_n)
        htt_en[3] |-> (pin_role[1:0] == 2'd0)); // R4
    AST_PCI7_ON_PIN6: assert property (@(posedge clk) disable iff (!rst_n)
        pci_en[7] |-> (pin_role[1:0] == 2'd1)); // R5
    AST_PCI6_NEEDS_PIN24: assert property (@(posedge clk) disable iff (!rst_n)
        pci_en[6] |-> pin24_oe); // R6
    AST_STOP_SPARES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_oe && pci_en == '0) |-> pcif_en); // R7
    AST_GATE_AT_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_oe && $past(ref_oe) && pci_en != $past(pci_en)) |-> $past(gate_low)); // R8
    AST_WDR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdreset_n) |-> $past(gear_change || wd_timeout)); // R10
    AST_WDR_NOT_TOO_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        !wdreset_n |-> (low_run < LR_W'(WDR_CYCLES))); // R10
    AST_WDR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdreset_n && low_run == LR_W'(WDR_CYCLES - 1) && !(ref_oe && (gear_change || wd_timeout)))
        |=> wdreset_n); // R10
endmodule

bind strap_pinmux strap_pinmux_checker #(.WDR_CYCLES(WDR_CYCLES)) u_chk (.*);

// File: tb/strap_pinmux_test.sv
module strap_pinmux_test;
    localparam int WDR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  fs_strap_in = '0;
    logic        mode_a_in = 0, mode_b_in = 0, mode_c_in = 0, sel_strap_in = 0;
    logic        pin24_in = 1, gate_low = 1, gear_change = 0, wd_timeout = 0;
    logic [3:0]  fs_q;
    logic        sel_24m, ref_oe, pcif_en, pin24_oe, wdreset_n;
    logic [10:0] pci_en;
    logic [3:0]  htt_en;
    logic [7:0]  pin_role;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    string pci_tag = "R7";

    always #2 clk = ~clk;

    strap_pinmux #(.WDR_CYCLES(WDR)) uut (.*);

    // behavioural model state
    bit       m_samp = 0, m_rel = 0, m_run = 1;
    bit [3:0] m_fs = 0;
    bit       m_ma = 0, m_mb = 0, m_mc = 0, m_sel = 0;
    int       m_wcnt = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_samp = 0; m_rel = 0; m_run = 1; m_wcnt = 0;
            m_fs = 0; m_ma = 0; m_mb = 0; m_mc = 0; m_sel = 0;
        end else begin
            bit was_rel;
            was_rel = m_rel;
            if (was_rel && (gear_change || wd_timeout)) m_wcnt = WDR;
            else if (m_wcnt > 0) m_wcnt = m_wcnt - 1;
            if (gate_low) m_run = !(was_rel && m_mc && !pin24_in);
            if (!m_samp) begin
                m_fs = fs_strap_in; m_ma = mode_a_in; m_mb = mode_b_in;
                m_mc = mode_c_in; m_sel = sel_strap_in; m_samp = 1;
            end else m_rel = 1;
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string mode_tag();
        if (!m_rel) return "R2";
        if (!m_ma && !m_mb) return "R3";
        if (m_mb) return "R4";
        return "R5";
    endfunction

    task automatic compare_all();
        logic [7:0]  e_role;
        logic [3:0]  e_htt;
        logic [10:0] e_pci;
        e_role = 0; e_htt = 0; e_pci = 0;
        if (m_rel) begin
            case ({m_ma, m_mb})
                2'b00: begin e_role = {2'd1, 2'd2, 2'd2, 2'd2}; e_htt = 4'b0111; e_pci[10] = 1; end
                2'b01: begin e_role = {2'd2, 2'd2, 2'd2, 2'd0}; e_htt = 4'b1110; end
                2'b10: begin e_role = {2'd1, 2'd1, 2'd1, 2'd1}; e_pci[10:7] = 4'hF; end
                default: begin e_role = {2'd1, 2'd1, 2'd1, 2'd0}; e_pci[10:8] = 3'h7; end
            endcase
            e_pci[5:0] = 6'h3F;
            e_pci[6] = !m_mc;
            if (!m_run) e_pci = 0;
        end
        chk("R1", "fs_q", 32'(fs_q), 32'(m_fs));
        chk("R9", "sel_24m", 32'(sel_24m), 32'(m_sel));
        chk("R2", "ref_oe", 32'(ref_oe), 32'(m_rel));
        chk("R7", "pcif_en", 32'(pcif_en), 32'(m_rel));
        chk(mode_tag(), "pin_role", 32'(pin_role), 32'(e_role));
        chk(mode_tag(), "htt_en", 32'(htt_en), 32'(e_htt));
        chk(m_rel ? pci_tag : "R2", "pci_en", 32'(pci_en), 32'(e_pci));
        chk("R6", "pin24_oe", 32'(pin24_oe), 32'(m_rel && !m_mc));
        chk("R10", "wdreset_n", 32'(wdreset_n), 32'(m_wcnt == 0));
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic run_config(int cfg);
        @(negedge clk);
        rst_n = 0;
        fs_strap_in = 4'(cfg * 5 + 3);
        {mode_a_in, mode_b_in, mode_c_in} = 3'(cfg);
        sel_strap_in = cfg[0] ^ cfg[2];
        pin24_in = 1; gate_low = 1; gear_change = 0; wd_timeout = 0;
        tick(2);                                  // R2 reset state
        rst_n = 1;
        tick(1);                                  // capture edge has passed: R1
        fs_strap_in = ~fs_strap_in;               // later strap changes ignored (R1)
        {mode_a_in, mode_b_in, mode_c_in, sel_strap_in} = ~{mode_a_in, mode_b_in, mode_c_in, sel_strap_in};
        gear_change = 1;                          // before release: ignored (R10)
        tick(1);
        gear_change = 0;
        tick(4);
        if (cfg[0]) begin                         // pin 24 is a stop input
            pci_tag = "R8";
            pin24_in = 0; gate_low = 0; tick(3);  // no low phase: still running
            gate_low = 1; tick(1);                // stop taken
            gate_low = 0; pin24_in = 1; tick(3);  // held stopped
            gate_low = 1; tick(1);                // restart taken
            tick(2);
            pci_tag = "R7";
            pin24_in = 0; tick(4);
            pin24_in = 1; tick(2);
        end else begin
            pci_tag = "R7";
            pin24_in = 0; gate_low = 1; tick(4);  // no effect when pin 24 is an output
            pin24_in = 1; tick(1);
        end
        gear_change = 1; tick(1); gear_change = 0;
        tick(WDR + 3);                            // R10 full pulse
        wd_timeout = 1; tick(1); wd_timeout = 0;
        tick(5);
        gear_change = 1; tick(1); gear_change = 0; // R10 restart
        tick(WDR + 3);
    endtask

    initial begin
        tick(2);
        for (int c = 0; c < 8; c++) run_config(c);
        run_config(5);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule